// File: doc/BRIEF.md
# Transmit Sample FIFO with Underrun Hold

This block buffers sample words between a host write port and a serial sample transmitter. The host pushes 16-bit words. Once per sample slot the transmitter fetches one word, which is presented on a registered output that holds its value between fetches. A fill counter drives a low-water service flag. The host can route that flag to an interrupt through a mask input.

When the transmitter fetches from an empty FIFO, the output keeps the last word actually delivered, so the line repeats that sample and does not send noise. At the same moment a sticky underrun bit is set. It drives an interrupt line that cannot be masked, and it stays set until the host writes a one to clear it. When fresh words are pushed, the next fetch delivers them as normal.

Top module: `tx_fifo_hold`

## Requirements
- R1: After reset the fill level is 0, `tx_data_o` is 0, `unr_o` is 0 and `srq_o` is 1.
- R2: Words leave in the order they were pushed. A fetch on a non-empty FIFO updates `tx_data_o` on the clock edge that accepts it, and the level drops by one.
- R3: The FIFO holds 16 words. A push while the level is 16 is dropped: the level stays 16 and the stored words are unchanged. Fullness is judged before any fetch in the same cycle.
- R4: `srq_o` is 1 while the level is below 4 and 0 while the level is 4 or more.
- R5: `srq_irq_o` is 1 only when both `srq_o` and `srq_mask_i` are 1.
- R6: A fetch while the level is 0 sets `unr_o` on that edge and leaves `tx_data_o` at its previous value.
- R7: `unr_o` stays set through later successful fetches. A cycle with `unr_clr_i`=1 and no empty fetch clears it.
- R8: When an empty fetch and `unr_clr_i` occur in the same cycle, `unr_o` ends set.
- R9: `unr_irq_o` equals `unr_o` and does not depend on `srq_mask_i`.
- R10: After an underrun, a word that is pushed and then fetched appears on `tx_data_o`.
- R11: A push and a fetch in the same cycle, with the level between 1 and 15, leave the level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| push_i | input | 1 | Host push strobe |
| push_data_i | input | 16 | Word to push |
| pop_i | input | 1 | Transmitter fetch strobe, one per sample slot |
| tx_data_o | output | 16 | Word being transmitted (held) |
| level_o | output | 5 | Current fill level |
| srq_mask_i | input | 1 | Enable for the service interrupt |
| srq_o | output | 1 | Low-water service flag |
| srq_irq_o | output | 1 | Masked service interrupt |
| unr_clr_i | input | 1 | Host write-one-to-clear of the underrun bit |
| unr_o | output | 1 | Sticky underrun status |
| unr_irq_o | output | 1 | Unmaskable underrun interrupt |

## Verification
Two functions can fall in the same cycle: the host's write-one clear of the underrun bit and a new empty fetch that sets it. The bench first sets the bit with an empty fetch. It then drives `pop_i` and `unr_clr_i` together on an empty FIFO and expects the bit still set after that edge. A later clear on its own must drop the bit. A second overlap, a push and a fetch in one cycle, is judged by an unchanged level and by the word delivered.

// File: rtl/tx_fifo_pkg.sv
package tx_fifo_pkg;
  parameter int unsigned DATA_W   = 16;
  parameter int unsigned DEPTH    = 16;
  parameter int unsigned LOW_MARK = 4;
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned LW = AW + 1;
  typedef logic [DATA_W-1:0] word_t;
  typedef logic [LW-1:0]     level_t;
endpackage

// File: rtl/tx_fifo_store.sv
module tx_fifo_store
  import tx_fifo_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   push_i,
  input  word_t  push_data_i,
  input  logic   pop_i,
  output word_t  tx_data_o,
  output level_t level_o,
  output logic   empty_o
);
  word_t         mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  level_t        level_q;
  word_t         hold_q;

  logic full, empty, do_push, do_pop;
  assign full    = (level_q == level_t'(DEPTH));
  assign empty   = (level_q == '0);
  assign do_push = push_i && !full;
  assign do_pop  = pop_i && !empty;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
      hold_q   <= '0;
    end else begin
      if (do_push) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (do_pop) begin
        rd_ptr_q <= rd_ptr_q + 1'b1;
        hold_q   <= mem_q[rd_ptr_q];
      end
      // empty fetch: hold_q keeps last delivered word
      case ({do_push, do_pop})
        2'b10:   level_q <= level_q + 1'b1;
        2'b01:   level_q <= level_q - 1'b1;
        default: level_q <= level_q;
      endcase
    end
  end

  assign tx_data_o = hold_q;
  assign level_o   = level_q;
  assign empty_o   = empty;

  p_level_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_q <= level_t'(DEPTH));
  p_full_drop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && level_q == level_t'(DEPTH)) |=> level_q == level_t'(DEPTH));
  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && level_q == '0) |=> $stable(hold_q));
  p_simul_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && level_q != '0 && level_q != level_t'(DEPTH)) |=> $stable(level_q));
endmodule

// File: rtl/tx_fifo_status.sv
module tx_fifo_status
  import tx_fifo_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  level_t level_i,
  input  logic   empty_fetch_i,
  input  logic   srq_mask_i,
  input  logic   unr_clr_i,
  output logic   srq_o,
  output logic   srq_irq_o,
  output logic   unr_o,
  output logic   unr_irq_o
);
  logic unr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            unr_q <= 1'b0;
    else if (empty_fetch_i) unr_q <= 1'b1;   // set beats clear
    else if (unr_clr_i)     unr_q <= 1'b0;
  end

  assign srq_o     = (level_i < level_t'(LOW_MARK));
  assign srq_irq_o = srq_o && srq_mask_i;
  assign unr_o     = unr_q;
  assign unr_irq_o = unr_q;

  p_unr_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_fetch_i |=> unr_q);
  p_unr_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unr_q && !unr_clr_i) |=> unr_q);
  p_unr_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unr_clr_i && !empty_fetch_i) |=> !unr_q);
  p_clr_collide_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unr_clr_i && empty_fetch_i) |=> unr_q);
  p_srq_high_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_i == '0) |-> srq_o);
endmodule

// File: rtl/tx_fifo_hold.sv
module tx_fifo_hold
  import tx_fifo_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] tx_data_o,
  output logic [LW-1:0]     level_o,
  input  logic              srq_mask_i,
  output logic              srq_o,
  output logic              srq_irq_o,
  input  logic              unr_clr_i,
  output logic              unr_o,
  output logic              unr_irq_o
);
  logic empty;

  tx_fifo_store u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push_i),
    .push_data_i (push_data_i),
    .pop_i       (pop_i),
    .tx_data_o   (tx_data_o),
    .level_o     (level_o),
    .empty_o     (empty)
  );

  tx_fifo_status u_status (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .level_i       (level_o),
    .empty_fetch_i (pop_i && empty),
    .srq_mask_i    (srq_mask_i),
    .unr_clr_i     (unr_clr_i),
    .srq_o         (srq_o),
    .srq_irq_o     (srq_irq_o),
    .unr_o         (unr_o),
    .unr_irq_o     (unr_irq_o)
  );

  p_irq_follow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unr_irq_o == unr_o);
endmodule

// File: tb/tx_fifo_hold_bench.sv
`timescale 1ns/1ps
module tx_fifo_hold_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push = 1'b0, pop = 1'b0, mask = 1'b0, clr = 1'b0;
  logic [15:0] din = '0;
  logic [15:0] tx;
  logic [4:0]  level;
  logic        srq, srq_irq, unr, unr_irq;
  int          n_chk = 0, n_err = 0;

  always #2.5 clk = ~clk;

  tx_fifo_hold u_tx_fifo_hold (
    .clk_i(clk), .rst_ni(rst_n), .push_i(push), .push_data_i(din), .pop_i(pop),
    .tx_data_o(tx), .level_o(level), .srq_mask_i(mask), .srq_o(srq),
    .srq_irq_o(srq_irq), .unr_clr_i(clr), .unr_o(unr), .unr_irq_o(unr_irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one clock: inputs set at negedge, outputs sampled 1 ns after posedge
  task automatic step();
    @(posedge clk); #1;
    push = 0; pop = 0; clr = 0;
  endtask

  task automatic do_push(input logic [15:0] w);
    @(negedge clk); push = 1; din = w; step();
  endtask

  task automatic do_pop();
    @(negedge clk); pop = 1; step();
  endtask

  task automatic t_reset();
    chk(level == 0, "R1", level, 0);
    chk(tx == 0, "R1", tx, 0);
    chk(unr == 0, "R1", unr, 0);
    chk(srq == 1, "R1", srq, 1);
    chk(unr_irq == 0, "R9", unr_irq, 0);
  endtask

  task automatic t_order();
    for (int i = 0; i < 5; i++) do_push(16'hA000 + 16'(i));
    chk(level == 5, "R2", level, 5);
    for (int i = 0; i < 5; i++) begin
      do_pop();
      chk(tx == 16'hA000 + 16'(i), "R2", tx, 16'hA000 + i);
      chk(level == 5'(4 - i), "R2", level, 4 - i);
    end
  endtask

  task automatic t_threshold();
    for (int i = 0; i < 3; i++) do_push(16'h3000 + 16'(i));
    chk(srq == 1, "R4", srq, 1);
    chk(srq_irq == 0, "R5", srq_irq, 0);
    mask = 1; #1;
    chk(srq_irq == 1, "R5", srq_irq, 1);
    do_push(16'h3003);
    chk(srq == 0, "R4", srq, 0);
    chk(srq_irq == 0, "R5", srq_irq, 0);
    do_pop();
    chk(srq == 1 && level == 3, "R4", srq, 1);
    mask = 0; #1;
    chk(srq_irq == 0, "R5", srq_irq, 0);
    for (int i = 0; i < 3; i++) do_pop();
  endtask

  task automatic t_full();
    for (int i = 0; i < 16; i++) do_push(16'hB000 + 16'(i));
    chk(level == 16, "R3", level, 16);
    do_push(16'hDEAD);
    chk(level == 16, "R3", level, 16);
    for (int i = 0; i < 16; i++) begin
      do_pop();
      chk(tx == 16'hB000 + 16'(i), "R3", tx, 16'hB000 + i);
    end
    chk(level == 0, "R3", level, 0);
  endtask

  task automatic t_underrun();
    do_pop();
    chk(unr == 1, "R6", unr, 1);
    chk(tx == 16'hB00F, "R6", tx, 16'hB00F);
    chk(unr_irq == 1 && mask == 0, "R9", unr_irq, 1);
    do_pop();
    chk(tx == 16'hB00F, "R6", tx, 16'hB00F);
    do_push(16'hC001);
    do_pop();
    chk(tx == 16'hC001, "R10", tx, 16'hC001);
    chk(unr == 1, "R7", unr, 1);
    @(negedge clk); clr = 1; step();
    chk(unr == 0, "R7", unr, 0);
    chk(unr_irq == 0, "R9", unr_irq, 0);
  endtask

  task automatic t_collision();
    do_pop();
    chk(unr == 1, "R6", unr, 1);
    @(negedge clk); pop = 1; clr = 1; step();
    chk(unr == 1, "R8", unr, 1);
    chk(tx == 16'hC001, "R8", tx, 16'hC001);
    @(negedge clk); clr = 1; step();
    chk(unr == 0, "R8", unr, 0);
  endtask

  task automatic t_simul();
    do_push(16'hD000);
    do_push(16'hD001);
    @(negedge clk); push = 1; din = 16'hD002; pop = 1; step();
    chk(level == 2, "R11", level, 2);
    chk(tx == 16'hD000, "R11", tx, 16'hD000);
    do_pop();
    chk(tx == 16'hD001, "R11", tx, 16'hD001);
    do_pop();
    chk(tx == 16'hD002 && level == 0, "R11", tx, 16'hD002);
    chk(unr == 0, "R7", unr, 0);
  endtask

  initial begin
    fork
      begin
        #12 rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_order();
        t_threshold();
        t_full();
        t_underrun();
        t_collision();
        t_simul();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule